// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Set-on-Less

This block is a purely combinational arithmetic logic unit built from a row of identical one-bit slices. Each slice can complement either of its operand bits. It then selects one of four values through a four-way multiplexer: the bitwise AND, the bitwise OR, the full-adder sum, or a less-than input. The carry passes from slice to slice as a plain ripple chain. The operand width is a parameter with a default of 32 and a minimum of 2.

A 4-bit control word selects the operation. From the most significant bit down, it holds an invert-A flag, an invert-B flag and a 2-bit function select. The invert-B flag also drives the carry into bit 0, so the adder forms A + ~B + 1 when B is inverted. This one path supplies subtraction and the signed comparison.

Only the top slice produces the set bit and the signed-overflow flag. The set bit is routed back to the less input of bit 0. All other less inputs are held at 0. A zero flag goes high when every result bit is 0, which gives an equality test for conditional branches. With no clock or state, the outputs follow the inputs within the same cycle.

Top module: `bit_alu`

## Requirements
- R1: Control 4'b0000 gives result_o = a_i & b_i.
- R2: Control 4'b0001 gives result_o = a_i | b_i.
- R3: Control 4'b0010 gives result_o = (a_i + b_i) mod 2^WIDTH, and carry_o is the carry out of bit WIDTH-1 of that sum.
- R4: Control 4'b0110 gives result_o = a_i + ~b_i + 1, which is a_i - b_i, and carry_o is the carry out of that sum (1 when a_i >= b_i unsigned).
- R5: Control 4'b0111 gives result_o[WIDTH-1:1] = 0 and result_o[0] equal to bit WIDTH-1 of a_i + ~b_i + 1. There is no correction for overflow, so for a_i = 32'h7FFFFFFF and b_i = 32'hFFFFFFFF the result is 1.
- R6: Control 4'b1100 gives result_o = ~(a_i | b_i).
- R7: overflow_o equals the carry into bit WIDTH-1 XOR the carry out of bit WIDTH-1 for every control value. For add and subtract, this is 1 exactly on two's-complement overflow.
- R8: zero_o is 1 exactly when result_o is all zeros, for every control value.
- R9: Control values not listed above return the raw datapath value. The effective operands are A' = inv_a ? ~a_i : a_i and B' = inv_b ? ~b_i : b_i, and the carry in is inv_b. Function select 00 gives A'&B', 01 gives A'|B', 10 gives A'+B'+inv_b, and 11 gives the set bit in bit 0. For example, 4'b1000 gives ~a_i & b_i.
- R10: carry_o is the carry out of A'+B'+inv_b for every control value, including the logic operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| ctrl_i | input | 4 | {invert A, invert B, function select[1:0]} |
| result_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Carry out of the top slice |
| overflow_o | output | 1 | Carry into top slice XOR carry out of it |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The checks assume that the operands and the control word are settled two-state values, with no X or Z. They also assume the width is at least 2, so that the slice feeding the set bit back is never the same slice as bit 0. The bench only ever drives known values, and it changes them only just after a rising edge. Each result is compared at the following falling edge, once the ripple chain has settled. The stimulus includes directed corner operands, such as the signed extremes, all ones, equal operands, and opposite-sign sums that cannot overflow. It also covers every one of the sixteen control codes with random operands.

// File: rtl/bit_alu_pkg.sv
package bit_alu_pkg;
  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_SUM  = 2'b10,
    FN_LESS = 2'b11
  } fn_sel_e;

  typedef struct packed {
    logic    inv_a;
    logic    inv_b;
    fn_sel_e fn;
  } alu_ctrl_t;
endpackage

// File: rtl/bit_alu_full_adder.sv
module bit_alu_full_adder (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic prop;
  assign prop = x_i ^ y_i;
  assign s_o  = prop ^ c_i;
  assign c_o  = (x_i & y_i) | (c_i & prop);
endmodule

// File: rtl/bit_alu_slice.sv
module bit_alu_slice
  import bit_alu_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic    a_i,
  input  logic    b_i,
  input  logic    inv_a_i,
  input  logic    inv_b_i,
  input  logic    carry_i,
  input  logic    less_i,
  input  fn_sel_e fn_i,
  output logic    res_o,
  output logic    carry_o,
  output logic    set_o,
  output logic    ovf_o
);
  logic a_eff, b_eff, sum;

  assign a_eff = a_i ^ inv_a_i;
  assign b_eff = b_i ^ inv_b_i;

  bit_alu_full_adder u_fa (
    .x_i(a_eff),
    .y_i(b_eff),
    .c_i(carry_i),
    .s_o(sum),
    .c_o(carry_o)
  );

  always_comb begin
    unique case (fn_i)
      FN_AND:  res_o = a_eff & b_eff;
      FN_OR:   res_o = a_eff | b_eff;
      FN_SUM:  res_o = sum;
      FN_LESS: res_o = less_i;
      default: res_o = 1'b0;
    endcase
  end

  generate
    if (IS_TOP) begin : g_top
      // raw sign of the difference; no overflow correction
      assign set_o = sum;
      assign ovf_o = carry_i ^ carry_o;
    end else begin : g_mid
      assign set_o = 1'b0;
      assign ovf_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/bit_alu_zero_detect.sv
module bit_alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res_i,
  output logic             zero_o
);
  assign zero_o = ~|res_i;
endmodule

// File: rtl/bit_alu.sv
module bit_alu
  import bit_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [3:0]       ctrl_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             overflow_o,
  output logic             zero_o
);
  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] res;
  logic             set_msb;
  logic             ovf_msb;

  assign ctrl     = alu_ctrl_t'(ctrl_i);
  assign carry[0] = ctrl.inv_b;  // B inverted -> +1 completes two's complement

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      if (i == MSB) begin : g_msb
        bit_alu_slice #(.IS_TOP(1'b1)) u_slice (
          .a_i    (a_i[i]),
          .b_i    (b_i[i]),
          .inv_a_i(ctrl.inv_a),
          .inv_b_i(ctrl.inv_b),
          .carry_i(carry[i]),
          .less_i (1'b0),
          .fn_i   (ctrl.fn),
          .res_o  (res[i]),
          .carry_o(carry[i+1]),
          .set_o  (set_msb),
          .ovf_o  (ovf_msb)
        );
      end else begin : g_low
        logic set_unused, ovf_unused;
        bit_alu_slice #(.IS_TOP(1'b0)) u_slice (
          .a_i    (a_i[i]),
          .b_i    (b_i[i]),
          .inv_a_i(ctrl.inv_a),
          .inv_b_i(ctrl.inv_b),
          .carry_i(carry[i]),
          .less_i ((i == 0) ? set_msb : 1'b0),
          .fn_i   (ctrl.fn),
          .res_o  (res[i]),
          .carry_o(carry[i+1]),
          .set_o  (set_unused),
          .ovf_o  (ovf_unused)
        );
      end
    end
  endgenerate

  bit_alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .res_i (res),
    .zero_o(zero_o)
  );

  assign result_o   = res;
  assign carry_o    = carry[WIDTH];
  assign overflow_o = ovf_msb;
endmodule

// File: rtl/bit_alu_checker.sv
module bit_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [3:0]       ctrl_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             overflow_o,
  input logic             zero_o
);
  always_comb begin
    if (ctrl_i == 4'b0000) begin
      AST_AND_SUBSET: assert (((result_o & ~a_i) | (result_o & ~b_i)) == '0); // R1
    end
    if (ctrl_i == 4'b0001) begin
      AST_OR_COVERS: assert ((result_o & a_i) == a_i && (result_o & b_i) == b_i); // R2
    end
    if (ctrl_i == 4'b0010) begin
      AST_ADD_VALUE: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i})); // R3
      AST_NO_OVERFLOW: assert (!(a_i[WIDTH-1] != b_i[WIDTH-1] && overflow_o)); // R7
    end
    if (ctrl_i == 4'b0110) begin
      AST_SUB_VALUE: assert (result_o == a_i - b_i); // R4
      AST_EQ_ZERO: assert (zero_o == (a_i == b_i)); // R8
    end
    if (ctrl_i[1:0] == 2'b11) begin
      AST_SLT_FORM: assert (result_o[WIDTH-1:1] == '0); // R5
    end
  end
endmodule

bind bit_alu bit_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .ctrl_i    (ctrl_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .overflow_o(overflow_o),
  .zero_o    (zero_o)
);

// File: tb/bit_alu_tb.sv
module bit_alu_tb;
  localparam int W = 32;

  typedef struct {
    logic [W-1:0] res;
    logic         co;
    logic         ov;
    logic         z;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [3:0]   ctrl = 4'b0000;
  logic [W-1:0] res;
  logic         co, ov, z;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  bit_alu #(.WIDTH(W)) u_dut (
    .a_i(a), .b_i(b), .ctrl_i(ctrl),
    .result_o(res), .carry_o(co), .overflow_o(ov), .zero_o(z)
  );

  function automatic exp_t model(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] c, string tag);
    exp_t e;
    logic [W-1:0] xa, yb;
    logic [W:0]   full;
    logic [W-1:0] low;
    xa   = c[3] ? ~x : x;
    yb   = c[2] ? ~y : y;
    full = {1'b0, xa} + {1'b0, yb} + W'(c[2]);
    low  = {1'b0, xa[W-2:0]} + {1'b0, yb[W-2:0]} + W'(c[2]);
    case (c[1:0])
      2'b00:   e.res = xa & yb;
      2'b01:   e.res = xa | yb;
      2'b10:   e.res = full[W-1:0];
      default: e.res = {{(W-1){1'b0}}, full[W-1]};
    endcase
    e.co  = full[W];
    e.ov  = low[W-1] ^ full[W];
    e.z   = (e.res == '0);
    e.tag = tag;
    return e;
  endfunction

  task automatic check(string what, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] c, string tag);
    @(posedge clk);
    #1;
    a = x; b = y; ctrl = c;
    q.push_back(model(x, y, c, tag));
  endtask

  // monitor: compare at the falling edge after each drive
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check("result",   e.tag, res, e.res);
      check("carry",    e.tag == "R3" || e.tag == "R4" ? e.tag : "R10", W'(co), W'(e.co));
      check("overflow", "R7", W'(ov), W'(e.ov));
      check("zero",     "R8", W'(z),  W'(e.z));
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("reset result", "R8", res, '0);
    check("reset zero",   "R8", W'(z), W'(1'b1));
    rst_ni = 1'b1;

    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0000, "R1");
    drive(32'hFFFF_FFFF, 32'h0000_0000, 4'b0000, "R1");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b0001, "R2");
    drive(32'h0000_0000, 32'h0000_0000, 4'b0001, "R2");
    drive(32'h0000_0005, 32'h0000_0007, 4'b0010, "R3");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 4'b0010, "R3");  // carry out, zero result
    drive(32'h7FFF_FFFF, 32'h0000_0001, 4'b0010, "R7");  // positive overflow
    drive(32'h8000_0000, 32'h8000_0000, 4'b0010, "R7");  // negative overflow
    drive(32'h8000_0000, 32'h7FFF_FFFF, 4'b0010, "R7");  // mixed signs, none
    drive(32'h0000_0009, 32'h0000_0004, 4'b0110, "R4");
    drive(32'h0000_0004, 32'h0000_0009, 4'b0110, "R4");
    drive(32'h1234_5678, 32'h1234_5678, 4'b0110, "R8");  // equal -> zero
    drive(32'h8000_0000, 32'h0000_0001, 4'b0110, "R7");  // sub overflow
    drive(32'hFFFF_FFFE, 32'h0000_0003, 4'b0111, "R5");  // -2 < 3
    drive(32'h0000_0003, 32'hFFFF_FFFE, 4'b0111, "R5");
    drive(32'h0000_0007, 32'h0000_0007, 4'b0111, "R5");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'b0111, "R5");  // raw set bit = 1
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b1100, "R6");
    drive(32'h0000_0000, 32'h0000_0000, 4'b1100, "R6");
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b1000, "R9");  // ~A & B
    drive(32'hF0F0_1234, 32'h0FF0_FF00, 4'b1001, "R9");
    drive(32'h0000_0003, 32'h0000_0005, 4'b1110, "R9");
    drive(32'hFFFF_FFFF, 32'h0000_0001, 4'b0100, "R10");  // logic op, adder carry
    for (int k = 0; k < 64; k++) begin
      logic [3:0] c;
      c = 4'(k % 16);
      drive($urandom(), $urandom(), c, "R9");
    end

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule